// File: doc/BRIEF.md
# Widening Half-to-Single Fused Multiply-Accumulate Lanes

This block is a SIMD lane datapath. It takes a vector of half-precision (FP16) multiplicands, multiplies each one by a single FP16 scalar that is broadcast to every lane, and adds each exact product to a single-precision (FP32) accumulator lane. The block rounds only once, on the final sum, using round-to-nearest-even, so no precision is lost between the multiply and the add.

The multiplicands are taken from one half of the first source vector. The scalar is one indexed halfword of the second source vector. A width select chooses between a 2-lane (64-bit) form and a 4-lane (128-bit) form. A negate select turns the operation into a multiply-subtract. Subnormal inputs in both formats are handled without flushing to zero. Any NaN gives the default quiet NaN. Sticky-style exception flags are collected across the active lanes. One encoding bit is reserved: when it is set the block reports an illegal operation and keeps its previous result.

The result, the flags and the illegal indication are registered, so they appear one clock after the request and are qualified by an output valid.

Top module: `fp16_widen_mac`

## Requirements
- R1: `out_valid_o` is high in the cycle after a clock edge that sampled `in_valid_i` high, and low after an edge that sampled it low. `result_o`, `flags_o` and `illegal_o` update at that same edge.
- R2: With `wide_i`=0 the block computes 2 lanes (result bits 63:0) and drives result bits 127:64 to zero. With `wide_i`=1 it computes 4 lanes.
- R3: Lane e takes its multiplicand from halfword (base+e) of `src_a_i`, where halfword k is bits 16k+15:16k. The base is 0 when `upper_i`=0. When `upper_i`=1 the base is 2 in the 2-lane form and 4 in the 4-lane form.
- R4: The scalar is halfword `elem_idx_i` of `src_b_i`, so index 0 is bits 15:0 and index 7 is bits 127:112. The same scalar is used in every lane.
- R5: With `negate_i`=1 the sign bit of each multiplicand is inverted before the multiply, which gives acc − a·s.
- R6: Each lane returns acc + a·s rounded exactly once to FP32 with round-to-nearest-even (ties go to an even significand). There is no intermediate rounding of the product. `flags_o[0]` (inexact) is set when the rounded result differs from the exact sum.
- R7: FP16 subnormal operands and FP32 subnormal accumulators enter the computation with their exact value, and results below the FP32 normal range are returned as exact subnormals, with no flush to zero.
- R8: A NaN in any lane operand gives 0x7FC00000 in that lane. `flags_o[3]` (invalid) is set by a signaling NaN (quiet bit clear), by infinity times zero, or by a sum of opposite-signed infinities. A quiet NaN alone does not set invalid.
- R9: An infinite product or an infinite accumulator, when no invalid case applies, gives an infinity with that operand's sign.
- R10: An exact zero sum is +0 when nonzero terms cancel or when the two zero terms differ in sign. It is −0 only when both terms are −0.
- R11: `flags_o` is {invalid, overflow, underflow, inexact} from bit 3 down to bit 0. It is the OR of the flags of the active lanes only, so lanes that are not active never raise a flag.
- R12: A request with `size_bit_i`=1 gives `illegal_o`=1 and `flags_o`=0 and leaves `result_o` unchanged. A later legal request clears `illegal_o`.
- R13: After reset, `out_valid_o`, `result_o`, `flags_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| src_a_i | input | 128 | Multiplicand vector, eight FP16 halfwords |
| src_b_i | input | 128 | Scalar source, eight FP16 halfwords |
| acc_i | input | 128 | Accumulator vector, four FP32 lanes |
| wide_i | input | 1 | 0: 2-lane form, 1: 4-lane form |
| upper_i | input | 1 | Picks the lower or upper half of `src_a_i` |
| negate_i | input | 1 | Inverts the multiplicand sign (multiply-subtract) |
| elem_idx_i | input | 3 | Scalar halfword index |
| size_bit_i | input | 1 | Reserved encoding bit; 1 is illegal |
| out_valid_o | output | 1 | Result qualifier, one cycle after the request |
| result_o | output | 128 | FP32 result lanes |
| flags_o | output | 4 | {invalid, overflow, underflow, inexact} |
| illegal_o | output | 1 | Last request had the reserved bit set |

## Verification
The bench builds the block with `N_LANES`=4, its default. At that value both the 2-lane and the 4-lane forms are reachable, as are all eight scalar indices and both halves of the multiplicand source, so every halfword of `src_a_i` can reach a lane. With four lanes, a single request can carry one lane per special case: a NaN, an infinity, a zero-sign case and a subnormal. The same setting also lets the 2-lane form leave signaling-NaN accumulators in lanes that are not active, to show that those lanes do not raise flags. The rounding vectors sit at the 2^24 boundary, where the FP32 spacing is 2, so they hit ties to both even and odd neighbours and a carry out of the significand.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam int H_W    = 16;
  localparam int S_W    = 32;
  // Fixed-point span: lsb weight 2^-149, top above 2^128
  localparam int FIX_W  = 280;
  localparam int P_BIAS = 101;   // product lsb offset: -48 + 149
  localparam logic [S_W-1:0] QNAN_S = 32'h7FC0_0000;

  typedef struct packed {
    logic [S_W-1:0] bits;
    logic           ovf;
    logic           unf;
    logic           inx;
  } pack_t;

  function automatic logic [10:0] half_sig(input logic [H_W-1:0] h);
    return {|h[14:10], h[9:0]};
  endfunction

  function automatic logic [4:0] half_shift(input logic [H_W-1:0] h);
    return (h[14:10] == 5'd0) ? 5'd0 : h[14:10] - 5'd1;
  endfunction

  // Exact FP16 x FP16 product on the fixed-point grid
  function automatic logic [FIX_W-1:0] prod_fix(input logic [H_W-1:0] a,
                                                input logic [H_W-1:0] b);
    logic [21:0] p;
    logic [8:0]  sh;
    p  = 22'(half_sig(a)) * 22'(half_sig(b));
    sh = 9'(half_shift(a)) + 9'(half_shift(b)) + 9'(P_BIAS);
    return FIX_W'(p) << sh;
  endfunction

  // Exact FP32 magnitude on the fixed-point grid
  function automatic logic [FIX_W-1:0] single_fix(input logic [S_W-1:0] c);
    logic [23:0] sig;
    logic [7:0]  sh;
    sig = {|c[30:23], c[22:0]};
    sh  = (c[30:23] == 8'd0) ? 8'd0 : c[30:23] - 8'd1;
    return FIX_W'(sig) << sh;
  endfunction

  // Single round-to-nearest-even of an exact magnitude into FP32
  function automatic pack_t round_pack(input logic sgn, input logic [FIX_W-1:0] mag);
    pack_t o;
    int lead, sh, ex;
    logic [FIX_W-1:0] rem, half, kept;
    logic [24:0] m25;
    logic up;
    lead = 0;
    for (int i = 0; i < FIX_W; i++) if (mag[i]) lead = i;
    sh   = (lead > 23) ? lead - 23 : 0;
    kept = mag >> sh;
    rem  = mag & ((FIX_W'(1) << sh) - FIX_W'(1));
    half = (sh > 0) ? (FIX_W'(1) << (sh - 1)) : '0;
    up   = (rem != '0) && ((rem > half) || ((rem == half) && kept[0]));
    m25  = {1'b0, kept[23:0]} + 25'(up);
    ex   = (lead >= 23) ? lead - 22 : 0;
    if (m25[24]) ex = ex + 1;
    o.inx = (rem != '0);
    o.unf = o.inx && (lead < 23);
    o.ovf = (ex >= 255);
    if (o.ovf) begin
      o.bits = {sgn, 8'hFF, 23'd0};
      o.inx  = 1'b1;
    end else begin
      o.bits = {sgn, 8'(ex), (m25[24] ? m25[23:1] : m25[22:0])};
    end
    return o;
  endfunction
endpackage

// File: rtl/wmac_lane_pick.sv
module wmac_lane_pick
  import wmac_pkg::*;
#(
  parameter int N_LANES = 4
) (
  input  logic [N_LANES*S_W-1:0]         src_a_i,
  input  logic [N_LANES*S_W-1:0]         src_b_i,
  input  logic [N_LANES*S_W-1:0]         acc_i,
  input  logic                           wide_i,
  input  logic                           upper_i,
  input  logic [$clog2(2*N_LANES)-1:0]   idx_i,
  output logic [N_LANES-1:0][H_W-1:0]    mul_o,
  output logic [H_W-1:0]                 scal_o,
  output logic [N_LANES-1:0][S_W-1:0]    acc_o,
  output logic [N_LANES-1:0]             act_o
);
  localparam int HW_N  = 2 * N_LANES;
  localparam int IDX_W = $clog2(HW_N);

  logic [HW_N-1:0][H_W-1:0] a_h;
  logic [HW_N-1:0][H_W-1:0] b_h;
  logic [IDX_W-1:0]         base;

  assign a_h = src_a_i;
  assign b_h = src_b_i;

  // Half offset: half the active datapath width, in halfwords
  always_comb begin
    if (!upper_i)     base = '0;
    else if (wide_i)  base = IDX_W'(N_LANES);
    else              base = IDX_W'(N_LANES / 2);
  end

  assign scal_o = b_h[idx_i];

  for (genvar e = 0; e < N_LANES; e++) begin : g_pick
    assign mul_o[e] = a_h[base + IDX_W'(e)];
    assign acc_o[e] = acc_i[e*S_W +: S_W];
    if (e < N_LANES / 2) begin : g_low
      assign act_o[e] = 1'b1;
    end else begin : g_high
      assign act_o[e] = wide_i;
    end
  end
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane
  import wmac_pkg::*;
(
  input  logic [H_W-1:0] mul_i,
  input  logic [H_W-1:0] scal_i,
  input  logic [S_W-1:0] acc_i,
  input  logic           neg_i,
  output logic [S_W-1:0] res_o,
  output logic [3:0]     flg_o,
  output logic           nan_o,
  output logic           inv_o
);
  logic sa, sb, sc, sp;
  logic a_nan, a_snan, a_inf, a_zero;
  logic b_nan, b_snan, b_inf, b_zero;
  logic c_nan, c_snan, c_inf;
  logic bad_mul, bad_add, p_inf;
  logic [FIX_W-1:0] pfix, cfix, mag;
  logic sgn;
  pack_t pk;

  always_comb begin
    sa     = mul_i[15] ^ neg_i;
    sb     = scal_i[15];
    sc     = acc_i[31];
    sp     = sa ^ sb;
    a_nan  = (&mul_i[14:10]) & (|mul_i[9:0]);
    a_snan = a_nan & ~mul_i[9];
    a_inf  = (&mul_i[14:10]) & ~(|mul_i[9:0]);
    a_zero = ~(|mul_i[14:0]);
    b_nan  = (&scal_i[14:10]) & (|scal_i[9:0]);
    b_snan = b_nan & ~scal_i[9];
    b_inf  = (&scal_i[14:10]) & ~(|scal_i[9:0]);
    b_zero = ~(|scal_i[14:0]);
    c_nan  = (&acc_i[30:23]) & (|acc_i[22:0]);
    c_snan = c_nan & ~acc_i[22];
    c_inf  = (&acc_i[30:23]) & ~(|acc_i[22:0]);

    p_inf   = a_inf | b_inf;
    bad_mul = (a_inf & b_zero) | (b_inf & a_zero);
    bad_add = p_inf & c_inf & (sp != sc);

    // Exact aligned sum, then one rounding
    pfix = prod_fix(mul_i, scal_i);
    cfix = single_fix(acc_i);
    if (sp == sc) begin
      mag = pfix + cfix;
      sgn = sp;
    end else if (pfix >= cfix) begin
      mag = pfix - cfix;
      sgn = sp;
    end else begin
      mag = cfix - pfix;
      sgn = sc;
    end
    if (mag == '0) sgn = sp & sc;
    pk = round_pack(sgn, mag);

    nan_o = a_nan | b_nan | c_nan | bad_mul | bad_add;
    inv_o = a_snan | b_snan | c_snan | bad_mul | bad_add;
    if (nan_o) begin
      res_o = QNAN_S;
      flg_o = {inv_o, 3'b000};
    end else if (p_inf) begin
      res_o = {sp, 8'hFF, 23'd0};
      flg_o = 4'b0000;
    end else if (c_inf) begin
      res_o = {sc, 8'hFF, 23'd0};
      flg_o = 4'b0000;
    end else begin
      res_o = pk.bits;
      flg_o = {1'b0, pk.ovf, pk.unf, pk.inx};
    end
  end
endmodule

// File: rtl/fp16_widen_mac.sv
module fp16_widen_mac
  import wmac_pkg::*;
#(
  parameter int N_LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid_i,
  input  logic [N_LANES*32-1:0]         src_a_i,
  input  logic [N_LANES*32-1:0]         src_b_i,
  input  logic [N_LANES*32-1:0]         acc_i,
  input  logic                          wide_i,
  input  logic                          upper_i,
  input  logic                          negate_i,
  input  logic [$clog2(2*N_LANES)-1:0]  elem_idx_i,
  input  logic                          size_bit_i,
  output logic                          out_valid_o,
  output logic [N_LANES*32-1:0]         result_o,
  output logic [3:0]                    flags_o,
  output logic                          illegal_o
);
  localparam int VEC_W = N_LANES * S_W;

  logic [N_LANES-1:0][H_W-1:0] lane_mul;
  logic [H_W-1:0]              scal;
  logic [N_LANES-1:0][S_W-1:0] lane_acc;
  logic [N_LANES-1:0]          act;
  logic [N_LANES-1:0][S_W-1:0] lane_res;
  logic [N_LANES-1:0][3:0]     lane_flg;
  logic [N_LANES-1:0]          lane_nan;
  logic [N_LANES-1:0]          lane_inv;
  logic [VEC_W-1:0]            nxt_res;
  logic [3:0]                  nxt_flg;

  wmac_lane_pick #(.N_LANES(N_LANES)) u_pick (
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .acc_i   (acc_i),
    .wide_i  (wide_i),
    .upper_i (upper_i),
    .idx_i   (elem_idx_i),
    .mul_o   (lane_mul),
    .scal_o  (scal),
    .acc_o   (lane_acc),
    .act_o   (act)
  );

  for (genvar e = 0; e < N_LANES; e++) begin : g_lane
    wmac_lane u_lane (
      .mul_i  (lane_mul[e]),
      .scal_i (scal),
      .acc_i  (lane_acc[e]),
      .neg_i  (negate_i),
      .res_o  (lane_res[e]),
      .flg_o  (lane_flg[e]),
      .nan_o  (lane_nan[e]),
      .inv_o  (lane_inv[e])
    );

    // R8: a NaN event in an active lane lands as the default NaN
    p_nan_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !size_bit_i && act[e] && lane_nan[e])
        |=> result_o[e*S_W +: S_W] == QNAN_S);
  end

  // Inactive lanes contribute neither data nor flags
  always_comb begin
    nxt_res = '0;
    nxt_flg = '0;
    for (int e = 0; e < N_LANES; e++) begin
      if (act[e]) begin
        nxt_res[e*S_W +: S_W] = lane_res[e];
        nxt_flg               = nxt_flg | lane_flg[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        if (size_bit_i) begin
          illegal_o <= 1'b1;
          flags_o   <= '0;
        end else begin
          illegal_o <= 1'b0;
          flags_o   <= nxt_flg;
          result_o  <= nxt_res;
        end
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);

  p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && size_bit_i) |=> (illegal_o && $stable(result_o) && flags_o == 4'd0));

  p_narrow_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !size_bit_i && !wide_i) |=> result_o[VEC_W-1:VEC_W/2] == '0);
endmodule

// File: tb/fp16_widen_mac_tb_top.sv
module fp16_widen_mac_tb_top;
  localparam int CLK_NS = 8;
  localparam int NV     = 11;

  typedef struct packed {
    logic         wide;
    logic         upper;
    logic         neg;
    logic [2:0]   idx;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
    logic [127:0] r;
    logic [3:0]   f;
  } vec_t;

  localparam logic [127:0] A0   = 128'h3E00_0000_BC00_3800_4400_4200_4000_3C00;
  localparam logic [127:0] B0   = 128'h4400_4200_4000_3C00_3800_BC00_3E00_C000;
  localparam logic [127:0] ONES = 128'h3F800000_3F800000_3F800000_3F800000;

  localparam vec_t TBL [NV] = '{
    // R2 R3 R4 R11: narrow, low half, idx5=2.0; sNaN accs in idle lanes
    '{1'b0, 1'b0, 1'b0, 3'd5, A0, B0, 128'h7FA00000_7FA00000_3F800000_3F800000,
      128'h00000000_00000000_40A00000_40400000, 4'b0000},
    // R3 R4: narrow, upper half, idx7=4.0
    '{1'b0, 1'b1, 1'b0, 3'd7, A0, B0, ONES,
      128'h00000000_00000000_41880000_41500000, 4'b0000},
    // R5 R10: wide, low half, negated, idx3=0.5; lane1 cancels to +0
    '{1'b1, 1'b0, 1'b1, 3'd3, A0, B0, ONES,
      128'hBF800000_BF000000_00000000_3F000000, 4'b0000},
    // R3 R4: wide, upper half, idx1=1.5
    '{1'b1, 1'b1, 1'b0, 3'd1, A0, B0, ONES,
      128'h40500000_3F800000_BF000000_3FE00000, 4'b0000},
    // R6: product kept exact (fp16-rounded product would give 2^-9)
    '{1'b0, 1'b0, 1'b0, 3'd0, 128'h3C00_3C01, 128'h3C01,
      128'h00000000_00000000_3F800000_BF800000,
      128'h00000000_00000000_40001000_3B001000, 4'b0000},
    // R6: ties to even at 2^24, carry out of significand
    '{1'b1, 1'b0, 1'b0, 3'd0, 128'h3C00_3E00_4200_3C00, 128'h3C00,
      128'h4B800001_4B7FFFFF_4B800000_4B800000,
      128'h4B800002_4B800000_4B800002_4B800000, 4'b0001},
    // R7 R11: max finite acc absorbs max product (no overflow); subnormal acc passes
    '{1'b0, 1'b0, 1'b0, 3'd0, 128'h0000_7BFF, 128'h7BFF,
      128'h00000000_00000000_80000005_7F7FFFFF,
      128'h00000000_00000000_80000005_7F7FFFFF, 4'b0001},
    // R8 R10 R7: scalar zero: inf*0, +0+-0, -0+-0, subnormal acc
    '{1'b1, 1'b0, 1'b0, 3'd0, 128'h0001_BC00_3C00_7C00, 128'h0,
      128'h00000001_80000000_80000000_3F800000,
      128'h00000001_80000000_00000000_7FC00000, 4'b1000},
    // R8 R9: qNaN, inf-inf, inf+1, sNaN acc
    '{1'b1, 1'b0, 1'b0, 3'd0, 128'h3C00_7C00_7C00_7E00, 128'h3C00,
      128'h7FA00000_3F800000_FF800000_3F800000,
      128'h7FC00000_7F800000_7FC00000_7FC00000, 4'b1000},
    // R8 R9: quiet NaN alone raises nothing; -1 + -inf
    '{1'b0, 1'b0, 1'b1, 3'd0, 128'h3C00_7E00, 128'h3C00,
      128'h00000000_00000000_FF800000_3F800000,
      128'h00000000_00000000_FF800000_7FC00000, 4'b0000},
    // R7: fp16 subnormal squared, subnormal scalar plus tiny acc
    '{1'b0, 1'b0, 1'b0, 3'd0, 128'h3C00_0001, 128'h0001,
      128'h00000000_00000000_00000001_00000000,
      128'h00000000_00000000_33800000_27800000, 4'b0001}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0, acc_i = '0;
  logic         wide_i = 1'b0, upper_i = 1'b0, negate_i = 1'b0, size_bit_i = 1'b0;
  logic [2:0]   elem_idx_i = '0;
  logic         out_valid_o;
  logic [127:0] result_o;
  logic [3:0]   flags_o;
  logic         illegal_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  fp16_widen_mac dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_i(acc_i),
    .wide_i(wide_i), .upper_i(upper_i), .negate_i(negate_i),
    .elem_idx_i(elem_idx_i), .size_bit_i(size_bit_i),
    .out_valid_o(out_valid_o), .result_o(result_o),
    .flags_o(flags_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic sz);
    @(negedge clk);
    in_valid_i = 1'b1;
    wide_i = v.wide; upper_i = v.upper; negate_i = v.neg; elem_idx_i = v.idx;
    src_a_i = v.a; src_b_i = v.b; acc_i = v.c; size_bit_i = sz;
    @(negedge clk);
    in_valid_i = 1'b0;
    size_bit_i = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    chk(out_valid_o == 1'b0, "R13 valid", 128'(out_valid_o), 128'd0);
    chk(result_o == '0,      "R13 result", result_o, 128'd0);
    chk(flags_o == 4'd0,     "R13 flags", 128'(flags_o), 128'd0);
    chk(illegal_o == 1'b0,   "R13 illegal", 128'(illegal_o), 128'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b0);
      $display("vector %0d", i);
      chk(out_valid_o == 1'b1,        "R1 out_valid", 128'(out_valid_o), 128'd1);
      chk(result_o == TBL[i].r,       "R2-table result", result_o, TBL[i].r);
      chk(flags_o == TBL[i].f,        "R11 flags", 128'(flags_o), 128'(TBL[i].f));
      chk(illegal_o == 1'b0,          "R12 legal", 128'(illegal_o), 128'd0);
    end

    // R1: idle cycle drops valid
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 idle", 128'(out_valid_o), 128'd0);

    // R12: reserved bit set keeps last result
    drive('{1'b1, 1'b0, 1'b0, 3'd4, A0, B0, ONES, 128'h0, 4'h0}, 1'b1);
    chk(out_valid_o == 1'b1, "R12 valid", 128'(out_valid_o), 128'd1);
    chk(illegal_o == 1'b1,   "R12 illegal", 128'(illegal_o), 128'd1);
    chk(flags_o == 4'd0,     "R12 flags", 128'(flags_o), 128'd0);
    chk(result_o == TBL[NV-1].r, "R12 hold", result_o, TBL[NV-1].r);

    // R12: next legal request clears illegal
    drive(TBL[0], 1'b0);
    chk(illegal_o == 1'b0,   "R12 clear", 128'(illegal_o), 128'd0);
    chk(result_o == TBL[0].r, "R12 resume", result_o, TBL[0].r);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule